// File: doc/BRIEF.md
# Converter Result Offset and Range Post-Processor

This block sits behind a successive-approximation converter core. It turns the core's signed, extended-range raw result into the final output word. When the core raises its done strobe, the block adds a programmable two's-complement offset to the raw result. It then forms the output word in one of two ways, chosen by a mode pin.

- **Clipped mode:** the low 14 bits carry the adjusted result clamped to the nominal code range, and the top bit reports whether the raw input lay outside that range.
- **Extended mode:** all 15 bits carry the adjusted result as an offset-binary word. This word saturates only at its own ends.

The output word and a one-cycle valid pulse appear one clock after the done strobe. Software loads the offset through a single-cycle write port. A write only affects conversions that complete after it. The output holds its last value between conversions.

Top module: `adc_offset_clip`

## Requirements
- R1: After reset `out_word` is 0 and `out_valid` is 0. The offset value is 0, so in clipped mode an in-range raw code comes out unchanged.
- R2: A cycle with `ofs_we` high loads `ofs_wdata` into the offset, read as 14-bit two's complement (-8192 to 8191). In any cycle without `ofs_we` the offset keeps its value.
- R3: On each conversion the adjusted value is the raw code (16-bit two's complement) plus the offset, computed at full signed precision.
- R4: With `clip_en` = 1, `out_word[13:0]` is the adjusted value clamped to 0..16383 (0x0000..0x3FFF).
- R5: With `clip_en` = 1, `out_word[14]` is 1 exactly when the raw code, before the offset, is below 0 or above 16383. It does not depend on the offset.
- R6: With `clip_en` = 0, `out_word` is the adjusted value plus 8192, clamped to 0..32767, on all 15 bits.
- R7: `out_valid` is high for exactly the one cycle after each cycle with `conv_done` high, including back-to-back strobes. `out_word` takes its new value in that same cycle.
- R8: In cycles that follow a cycle without `conv_done`, `out_word` keeps its previous value.
- R9: When `ofs_we` and `conv_done` are high in the same cycle, that conversion uses the old offset. The next conversion uses the written value.
- R10: `clip_en` and `raw_code` count only in the cycle with `conv_done`. Changing them in other cycles does not change `out_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | Conversion-complete strobe from the converter core |
| raw_code | input | 16 | Signed raw conversion result, valid with `conv_done` |
| ofs_we | input | 1 | Offset write enable |
| ofs_wdata | input | 14 | Offset write value, two's complement |
| clip_en | input | 1 | 1 = clipped 14-bit output with range flag, 0 = extended 15-bit output |
| out_word | output | 15 | Final output word |
| out_valid | output | 1 | One-cycle pulse marking a new `out_word` |

## Verification
Two events can fall in the same cycle: an offset write and a conversion-done strobe. The bench provokes this by raising `ofs_we` and `conv_done` together, then following with a second strobe carrying the same raw code. The first result must match the reference model computed with the old offset, and the second must match the model using the new offset. The reference model updates its own offset copy only after it has computed the result for that cycle.

// File: rtl/ofp_pkg.sv
package ofp_pkg;

    // Output formatting mode selected by the clip pin.
    typedef enum logic {
        RANGE_EXTENDED = 1'b0,
        RANGE_CLIPPED  = 1'b1
    } range_mode_e;

endpackage

// File: rtl/ofp_ofs_reg.sv
module ofp_ofs_reg #(
    parameter int OFS_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [OFS_W-1:0] wdata,
    output logic [OFS_W-1:0] ofs_q
);

    logic [OFS_W-1:0] ofs_d;

    always_comb begin
        ofs_d = ofs_q;
        if (we) begin
            ofs_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q <= '0;
        end else begin
            ofs_q <= ofs_d;
        end
    end

    // R2: a write lands in the register on the next edge
    a_r2_offset_load: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ofs_q == $past(wdata)));

    // R2: without a write the register keeps its value
    a_r2_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(ofs_q));

endmodule

// File: rtl/ofp_range_det.sv
module ofp_range_det #(
    parameter int RAW_W  = 16,
    parameter int CORE_W = 14
) (
    input  logic [RAW_W-1:0] raw,
    output logic             out_of_range
);

    localparam int                 MAG_W   = RAW_W - 1;
    localparam logic [MAG_W-1:0]   NOM_TOP = MAG_W'((1 << CORE_W) - 1);

    logic below_zero;
    logic above_top;

    always_comb begin
        below_zero   = raw[RAW_W-1];
        above_top    = !below_zero && (raw[MAG_W-1:0] > NOM_TOP);
        out_of_range = below_zero || above_top;
    end

endmodule

// File: rtl/ofp_sat.sv
module ofp_sat
    import ofp_pkg::*;
#(
    parameter int RAW_W  = 16,
    parameter int OFS_W  = 14,
    parameter int CORE_W = 14
) (
    input  logic [RAW_W-1:0]  raw,
    input  logic [OFS_W-1:0]  ofs,
    input  range_mode_e       mode,
    input  logic              ovr,
    output logic [CORE_W:0]   word
);

    localparam int OUT_W      = CORE_W + 1;
    localparam int SUM_W      = ((RAW_W > OFS_W) ? RAW_W : OFS_W) + 2;
    localparam int CORE_MAX_I = (1 << CORE_W) - 1;
    localparam int EXT_MAX_I  = (1 << OUT_W) - 1;
    localparam int BIAS_I     = 1 << (CORE_W - 1);

    localparam logic signed [SUM_W-1:0] CORE_MAX = SUM_W'(CORE_MAX_I);
    localparam logic signed [SUM_W-1:0] EXT_MAX  = SUM_W'(EXT_MAX_I);
    localparam logic signed [SUM_W-1:0] BIAS     = SUM_W'(BIAS_I);

    logic signed [SUM_W-1:0] raw_x;
    logic signed [SUM_W-1:0] ofs_x;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] biased;
    logic [CORE_W-1:0]       core_code;
    logic [OUT_W-1:0]        ext_code;

    // Sign extension of both operands to the common sum width
    always_comb begin
        raw_x  = {{(SUM_W-RAW_W){raw[RAW_W-1]}}, raw};
        ofs_x  = {{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs};
        sum    = raw_x + ofs_x;
        biased = sum + BIAS;
    end

    // Nominal clamp for clipped mode
    always_comb begin
        if (sum[SUM_W-1]) begin
            core_code = '0;
        end else if (sum > CORE_MAX) begin
            core_code = '1;
        end else begin
            core_code = sum[CORE_W-1:0];
        end
    end

    // Extended clamp on the biased value
    always_comb begin
        if (biased[SUM_W-1]) begin
            ext_code = '0;
        end else if (biased > EXT_MAX) begin
            ext_code = '1;
        end else begin
            ext_code = biased[OUT_W-1:0];
        end
    end

    always_comb begin
        if (mode == RANGE_CLIPPED) begin
            word = {ovr, core_code};
        end else begin
            word = ext_code;
        end
    end

endmodule

// File: rtl/adc_offset_clip.sv
module adc_offset_clip
    import ofp_pkg::*;
#(
    parameter int RAW_W  = 16,
    parameter int OFS_W  = 14,
    parameter int CORE_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [RAW_W-1:0]  raw_code,
    input  logic              ofs_we,
    input  logic [OFS_W-1:0]  ofs_wdata,
    input  logic              clip_en,
    output logic [CORE_W:0]   out_word,
    output logic              out_valid
);

    localparam int OUT_W   = CORE_W + 1;
    localparam int NOM_MAX = (1 << CORE_W) - 1;

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] word;
    } out_state_t;

    out_state_t       state_d;
    out_state_t       state_q;
    logic [OFS_W-1:0] ofs_q;
    logic             ovr_flag;
    logic [OUT_W-1:0] fmt_word;
    range_mode_e      mode_sel;

    assign mode_sel = clip_en ? RANGE_CLIPPED : RANGE_EXTENDED;

    ofp_ofs_reg #(
        .OFS_W (OFS_W)
    ) i_ofs_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ofs_we),
        .wdata (ofs_wdata),
        .ofs_q (ofs_q)
    );

    ofp_range_det #(
        .RAW_W  (RAW_W),
        .CORE_W (CORE_W)
    ) i_range_det (
        .raw          (raw_code),
        .out_of_range (ovr_flag)
    );

    ofp_sat #(
        .RAW_W  (RAW_W),
        .OFS_W  (OFS_W),
        .CORE_W (CORE_W)
    ) i_sat (
        .raw  (raw_code),
        .ofs  (ofs_q),
        .mode (mode_sel),
        .ovr  (ovr_flag),
        .word (fmt_word)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = conv_done;
        if (conv_done) begin
            state_d.word = fmt_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_word  = state_q.word;
    assign out_valid = state_q.valid;

    // R7: a strobe yields a valid pulse on the next cycle
    a_r7_valid_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> out_valid);

    // R7: no strobe, no pulse
    a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> !out_valid);

    // R8: the word holds between conversions
    a_r8_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(out_word));

    // R5: in clipped mode an in-range raw code gives a clear flag
    a_r5_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && clip_en && ($signed(raw_code) >= 0) && ($signed(raw_code) <= NOM_MAX))
        |=> !out_word[CORE_W]);

    // R5: in clipped mode an out-of-range raw code sets the flag
    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && clip_en && (($signed(raw_code) < 0) || ($signed(raw_code) > NOM_MAX)))
        |=> out_word[CORE_W]);

endmodule

// File: tb/test_adc_offset_clip.sv
module test_adc_offset_clip;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [15:0] raw_code = '0;
    logic        ofs_we = 1'b0;
    logic [13:0] ofs_wdata = '0;
    logic        clip_en = 1'b1;
    logic [14:0] out_word;
    logic        out_valid;

    int          n_checks = 0;
    int          n_fails  = 0;
    int          mdl_ofs  = 0;
    logic [14:0] exp_word = '0;
    logic        exp_valid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_offset_clip i_adc_offset_clip (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .raw_code  (raw_code),
        .ofs_we    (ofs_we),
        .ofs_wdata (ofs_wdata),
        .clip_en   (clip_en),
        .out_word  (out_word),
        .out_valid (out_valid)
    );

    function automatic logic [14:0] ref_word(int raw, int ofs, bit clip);
        int s = raw + ofs;
        int c;
        logic flag;
        if (clip) begin
            c    = (s < 0) ? 0 : ((s > 16383) ? 16383 : s);
            flag = (raw < 0 || raw > 16383);
            return {flag, 14'(c)};
        end
        c = s + 8192;
        c = (c < 0) ? 0 : ((c > 32767) ? 32767 : c);
        return 15'(c);
    endfunction

    task automatic check(string tag);
        n_checks++;
        if (out_valid !== exp_valid || out_word !== exp_word) begin
            n_fails++;
            $display("FAIL %s: valid=%0b word=%h expected valid=%0b word=%h",
                     tag, out_valid, out_word, exp_valid, exp_word);
        end
    endtask

    // One clock: drive inputs, advance the model, then compare after the edge
    task automatic step(string tag, bit d, int raw, bit we, int wd, bit clip);
        @(negedge clk);
        conv_done = d;
        raw_code  = 16'(raw);
        ofs_we    = we;
        ofs_wdata = 14'(wd);
        clip_en   = clip;
        exp_valid = d;
        if (d) exp_word = ref_word(raw, mdl_ofs, clip);
        if (we) mdl_ofs = wd;
        @(posedge clk);
        #1;
        check(tag);
    endtask

    task automatic idle(string tag);
        step(tag, 1'b0, 0, 1'b0, 0, clip_en);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        // R1: offset is zero after reset
        step("R1 zero offset", 1'b1, 100, 1'b0, 0, 1'b1);
        idle("R8 hold");
        idle("R8 hold");

        // R4 R5: clipping with zero offset at and beyond both ends
        step("R4 above top", 1'b1, 20000, 1'b0, 0, 1'b1);
        step("R4 below zero", 1'b1, -50, 1'b0, 0, 1'b1);
        step("R4 exact top", 1'b1, 16383, 1'b0, 0, 1'b1);
        step("R4 exact zero", 1'b1, 0, 1'b0, 0, 1'b1);
        step("R5 just above", 1'b1, 16384, 1'b0, 0, 1'b1);

        // R2 R3: positive offset
        step("R2 write +1024", 1'b0, 0, 1'b1, 1024, 1'b1);
        step("R3 positive shift", 1'b1, 100, 1'b0, 0, 1'b1);
        step("R4 clamp with offset", 1'b1, 16000, 1'b0, 0, 1'b1);
        step("R5 flag ignores offset", 1'b1, -500, 1'b0, 0, 1'b1);

        // Negative offset
        step("R2 write -512", 1'b0, 0, 1'b1, -512, 1'b1);
        step("R4 negative clamp", 1'b1, 300, 1'b0, 0, 1'b1);
        step("R3 negative shift", 1'b1, 16383, 1'b0, 0, 1'b1);

        // R6: extended mode
        step("R6 biased", 1'b1, 100, 1'b0, 0, 1'b0);
        step("R6 low saturate", 1'b1, -20000, 1'b0, 0, 1'b0);
        step("R2 write max", 1'b0, 0, 1'b1, 8191, 1'b0);
        step("R6 high saturate", 1'b1, 30000, 1'b0, 0, 1'b0);
        step("R6 overrange kept", 1'b1, 17000, 1'b0, 0, 1'b0);
        step("R2 write min", 1'b0, 0, 1'b1, -8192, 1'b0);
        step("R6 min offset", 1'b1, 16383, 1'b0, 0, 1'b0);
        step("R4 min offset clipped", 1'b1, 5000, 1'b0, 0, 1'b1);
        step("R2 write zero", 1'b0, 0, 1'b1, 0, 1'b0);
        step("R6 top code", 1'b1, 16383, 1'b0, 0, 1'b0);
        step("R6 zero code", 1'b1, 0, 1'b0, 0, 1'b0);

        // R9: write and strobe in the same cycle
        step("R9 old offset used", 1'b1, 2000, 1'b1, 700, 1'b1);
        step("R9 new offset used", 1'b1, 2000, 1'b0, 0, 1'b1);

        // R10: inputs outside a strobe cycle do nothing
        step("R10 clip toggled idle", 1'b0, 30000, 1'b0, 0, 1'b0);
        step("R10 raw changed idle", 1'b0, -9000, 1'b0, 0, 1'b1);

        // R7: back-to-back strobes
        step("R7 burst 1", 1'b1, 1, 1'b0, 0, 1'b1);
        step("R7 burst 2", 1'b1, 16383, 1'b0, 0, 1'b0);
        step("R7 burst 3", 1'b1, -1, 1'b0, 0, 1'b1);
        idle("R7 pulse ends");
        idle("R8 hold after burst");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule